// File: doc/BRIEF.md
# Single-Channel Block-Move DMA Engine

This engine copies a block of words from one region of the system bus to another, without the processor taking part. Software loads a source address, a destination address and a word count through a small register port. It then chooses the options and sets the enable bit. When a peripheral asks for service on the trigger input, the engine raises a bus request to the arbiter. It touches the bus only after the grant arrives.

Each word takes two bus cycles. The first is a read at the source, and the returned data goes into an internal holding register. The second is a write of that register to the destination. After the write, the addresses step, the count drops by one, and the engine either goes on or gives the bus back.

In burst mode the bus is held for the whole block. In cycle-stealing mode the bus is requested and released once for each word. When the count runs out, the enable bit clears and a done flag sets. The done flag can drive an interrupt line.

Top module: `blkmove_dma`

## Requirements
- R1: After reset, bus_req, mem_rd, mem_wr and irq are low, and every register offset reads zero.
- R2: The register offsets are: 0 control, 1 source address, 2 destination address, 3 word count, 4 status. Writes to offsets 1–3 are ignored while the enable bit is set and accepted while it is clear.
- R3: A transfer starts by raising bus_req. mem_rd and mem_wr are asserted only while both bus_req and bus_gnt are high.
- R4: Each word is one mem_rd cycle at the source address, followed in the next cycle by one mem_wr cycle at the destination address carrying the data read. A block of N words gives exactly N reads and N writes.
- R5: In burst mode (control bit 1 = 1), bus_req rises once per block and stays high until the last write.
- R6: In cycle-stealing mode (control bit 1 = 0), bus_req falls after every write and rises once per word.
- R7: Control bit 3 makes the source address step by +1 per word, and bit 4 does the same for the destination. A clear bit keeps that address fixed. All four combinations move data accordingly, and the address registers read back their stepped values.
- R8: The count drops by one per word. When it reaches zero, the enable bit (control bit 0) clears and the done flag sets (control bit 6, status bit 0). bus_req is low in the cycle after the last write.
- R9: Setting enable with a count of zero sets done and clears enable with no bus request.
- R10: In level mode (control bit 2 = 0), a word or block starts only while xfer_trig is high. With the trigger low, nothing happens.
- R11: In edge mode (control bit 2 = 1), a rising edge of xfer_trig starts one word in cycle-stealing mode or the whole block in burst mode. An edge that arrives while busy is held and serves the next word.
- R12: irq equals done AND control bit 5. Writing 1 to status bit 0 clears done.
- R13: Clearing enable lets the word in flight finish, and no further words start. Triggers are then ignored.
- R14: The word count register holds values up to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data (combinational) |
| xfer_trig | input | 1 | Transfer request from the peripheral |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Word address for the bus cycle |
| mem_rd | output | 1 | Read strobe (source cycle) |
| mem_wr | output | 1 | Write strobe (destination cycle) |
| mem_wdata | output | DW | Write data from the holding register |
| mem_rdata | input | DW | Read data, valid in the read cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume a well-behaved arbiter and bus:
- bus_gnt rises only after bus_req, stays high for as long as bus_req is high, and falls soon after the request drops.
- mem_rdata is valid during the cycle in which mem_rd is high.
- xfer_trig is synchronous to clk.
- Software changes the mode bits only while the channel is disabled.

The bench's arbiter model holds the grant until the request falls and varies the grant delay from zero to three cycles. Its memory answers reads combinationally. All register writes and trigger pulses are driven on the falling clock edge.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_state_t;

  // register offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_SRC  = 1;
  localparam int OFS_DST  = 2;
  localparam int OFS_CNT  = 3;
  localparam int OFS_STAT = 4;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic ie;
    logic dinc;
    logic sinc;
    logic trig_edge;
    logic burst;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic int reg_width(input int aw, input int cw);
    int w;
    w = (aw > cw) ? aw : cw;
    return (w < 8) ? 8 : w;
  endfunction

endpackage

// File: rtl/blkmove_regs.sv
module blkmove_regs
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          word_done,
  output ctrl_t         ctrl,
  output logic          done,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          cnt_zero,
  output logic          cnt_last
);

  ctrl_t         ctrl_q, ctrl_n;
  logic          done_q, done_n;
  logic [AW-1:0] src_q, src_n;
  logic [AW-1:0] dst_q, dst_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CW'(1));

  always_comb begin
    ctrl_n = ctrl_q;
    done_n = done_q;
    src_n  = src_q;
    dst_n  = dst_q;
    cnt_n  = cnt_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        3'(OFS_CTRL): ctrl_n = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        3'(OFS_SRC):  if (!ctrl_q.en) src_n = cfg_wdata[AW-1:0];
        3'(OFS_DST):  if (!ctrl_q.en) dst_n = cfg_wdata[AW-1:0];
        3'(OFS_CNT):  if (!ctrl_q.en) cnt_n = cfg_wdata[CW-1:0];
        3'(OFS_STAT): if (cfg_wdata[0]) done_n = 1'b0;
        default: ;
      endcase
    end
    if (word_done) begin
      cnt_n = cnt_q - CW'(1);
      if (ctrl_q.sinc) src_n = src_q + AW'(1);
      if (ctrl_q.dinc) dst_n = dst_q + AW'(1);
      if (cnt_last) begin
        ctrl_n.en = 1'b0;
        done_n    = 1'b1;
      end
    end else if (ctrl_q.en && !busy && cnt_zero) begin
      ctrl_n.en = 1'b0;
      done_n    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      done_q <= done_n;
      src_q  <= src_n;
      dst_q  <= dst_n;
      cnt_q  <= cnt_n;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      3'(OFS_CTRL): cfg_rdata = RW'({done_q, ctrl_q});
      3'(OFS_SRC):  cfg_rdata = RW'(src_q);
      3'(OFS_DST):  cfg_rdata = RW'(dst_q);
      3'(OFS_CNT):  cfg_rdata = RW'(cnt_q);
      3'(OFS_STAT): cfg_rdata = RW'({busy, done_q});
      default:      cfg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign done = done_q;
  assign src  = src_q;
  assign dst  = dst_q;

  // a word completion lowers the count by exactly one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // the last word closes the channel
  assert_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && cnt_last) |=> (!ctrl_q.en && done_q));

  // source register is frozen while enabled except for stepping
  assert_src_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && !word_done) |=> $stable(src_q));

endmodule

// File: rtl/blkmove_trig.sv
module blkmove_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic en,
  input  logic edge_mode,
  input  logic take,
  output logic go
);

  logic trig_q;
  logic pend_q, pend_n;
  logic rise;

  assign rise = trig_in & ~trig_q;
  assign go   = edge_mode ? (pend_q | rise) : trig_in;

  always_comb begin
    if (!en || !edge_mode) pend_n = 1'b0;
    else if (take)         pend_n = pend_q & rise;
    else                   pend_n = pend_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      trig_q <= trig_in;
      pend_q <= pend_n;
    end
  end

  // an edge held while busy survives until it is consumed
  assert_pending_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take && en && edge_mode) |=> pend_q);

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          burst,
  input  logic          go,
  input  logic          cnt_zero,
  input  logic          cnt_last,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          bus_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          take,
  output logic          word_done,
  output logic          busy
);

  seq_state_t    st_q, st_n;
  logic [DW-1:0] hold_q;
  logic          hold_ld;

  assign take = (st_q == ST_IDLE) && en && go && !cnt_zero;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: if (take) st_n = ST_ASK;
      ST_ASK:  if (bus_gnt) st_n = ST_RD;
      ST_RD:   st_n = ST_WR;
      ST_WR:   st_n = (cnt_last || !burst || !en) ? ST_IDLE : ST_RD;
      default: st_n = ST_IDLE;
    endcase
  end

  assign hold_ld = (st_q == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_ld) hold_q <= mem_rdata;
  end

  assign busy      = (st_q != ST_IDLE);
  assign bus_req   = busy;
  assign mem_rd    = (st_q == ST_RD);
  assign mem_wr    = (st_q == ST_WR);
  assign word_done = mem_wr;
  assign mem_addr  = mem_wr ? dst : src;
  assign mem_wdata = hold_q;

  assert_strobe_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

  assert_burst_holds_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && burst && en && !cnt_last) |=> (bus_req && mem_rd));

  assert_steal_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !burst) |=> !bus_req);

  assert_last_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cnt_last) |=> !bus_req);

endmodule

// File: rtl/blkmove_dma.sv
module blkmove_dma
  import blkmove_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int RW = reg_width(AW, CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          xfer_trig,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  ctrl_t         ctrl;
  logic          done;
  logic [AW-1:0] src, dst;
  logic          cnt_zero, cnt_last;
  logic          go, take, word_done, busy;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  blkmove_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .word_done (word_done),
    .ctrl      (ctrl),
    .done      (done),
    .src       (src),
    .dst       (dst),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  blkmove_trig u_trig (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trig_in   (xfer_trig),
    .en        (ctrl.en),
    .edge_mode (ctrl.trig_edge),
    .take      (take),
    .go        (go)
  );

  blkmove_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (ctrl.en),
    .burst     (ctrl.burst),
    .go        (go),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .src       (src),
    .dst       (dst),
    .bus_gnt   (bus_gnt),
    .mem_rdata (mem_rdata),
    .bus_req   (bus_req),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .take      (take),
    .word_done (word_done),
    .busy      (busy)
  );

  assign irq = done & ctrl.ie;

  // level mode never starts without the trigger held high
  assert_level_needs_trigger_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take && !ctrl.trig_edge) |-> xfer_trig);

endmodule

// File: tb/blkmove_dma_bench.sv
module blkmove_dma_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int RW = 16;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SRC  = 3'd1;
  localparam logic [2:0] A_DST  = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic          xfer_trig = 1'b0;
  logic          bus_req;
  logic          bus_gnt;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          irq;

  blkmove_dma u_blkmove_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xfer_trig(xfer_trig),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model: refill on request, otherwise take bus writes
  logic [DW-1:0] mem [0:63];
  logic [DW-1:0] expm [0:63];
  logic          fill_req = 1'b0;
  int            seed = 0;

  function automatic logic [DW-1:0] patt(input int i, input int s);
    return DW'((i * 131 + s * 17 + 7) ^ (i << 9));
  endfunction

  assign mem_rdata = mem[mem_addr[5:0]];
  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 64; i++) mem[i] <= patt(i, seed);
    end else if (mem_wr) begin
      mem[mem_addr[5:0]] <= mem_wdata;
    end
  end

  // arbiter model: grant after gdly cycles, held while requested
  int gdly = 0;
  int gcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0; gcnt <= 0;
    end else if (!bus_req) begin
      bus_gnt <= 1'b0; gcnt <= 0;
    end else if (gcnt >= gdly) begin
      bus_gnt <= 1'b1;
    end else begin
      gcnt <= gcnt + 1;
    end
  end

  // monotonic bus monitors
  int   rd_n = 0, wr_n = 0, rises = 0, nogrant = 0;
  logic req_d = 1'b0;
  always @(posedge clk) begin
    req_d <= bus_req;
    if (rst_n) begin
      if (mem_rd) rd_n <= rd_n + 1;
      if (mem_wr) wr_n <= wr_n + 1;
      if (bus_req && !req_d) rises <= rises + 1;
      if ((mem_rd || mem_wr) && !(bus_req && bus_gnt)) nogrant <= nogrant + 1;
    end
  end

  int ncmp = 0;
  int nbad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [RW-1:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic refill();
    seed++;
    @(negedge clk); fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
    for (int i = 0; i < 64; i++) expm[i] = patt(i, seed);
  endtask

  task automatic pulse();
    @(negedge clk); xfer_trig = 1'b1;
    @(negedge clk); xfer_trig = 1'b0;
  endtask

  function automatic int mem_diff();
    int bad = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== expm[i]) bad++;
    return bad;
  endfunction

  task automatic run_case(input bit burst, input bit edg, input bit sinc,
                          input bit dinc, input bit ie, input int n, input int gd);
    logic [RW-1:0] v;
    int b_rd, b_wr, b_rq, cyc;
    bit fin;
    gdly = gd;
    refill();
    for (int k = 0; k < n; k++)
      expm[40 + (dinc ? k : 0)] = expm[8 + (sinc ? k : 0)];
    wr(A_SRC, 16'd8);
    wr(A_DST, 16'd40);
    wr(A_CNT, RW'(n));
    b_rd = rd_n; b_wr = wr_n; b_rq = rises;
    wr(A_CTRL, {10'd0, ie, dinc, sinc, edg, burst, 1'b1});
    fin = 1'b0; cyc = 0;
    while (!fin && cyc < 600) begin
      if (edg) xfer_trig = (cyc == 0) || (!burst && (cyc % 10 == 0));
      else     xfer_trig = 1'b1;
      @(negedge clk);
      cyc++;
      rd(A_STAT, v);
      fin = v[0];
    end
    xfer_trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 done reached", 32'(fin), 1);
    chk("R7 memory image", mem_diff(), 0);
    rd(A_SRC, v); chk("R7 final source", v, 8 + (sinc ? n : 0));
    rd(A_DST, v); chk("R7 final destination", v, 40 + (dinc ? n : 0));
    rd(A_CNT, v); chk("R8 count zero", v, 0);
    rd(A_CTRL, v);
    chk("R8 enable cleared, done set", v[6:0], {1'b1, ie, dinc, sinc, edg, burst, 1'b0});
    if (burst) chk("R5 one request per block", rises - b_rq, 1);
    else       chk("R6 one request per word", rises - b_rq, n);
    chk("R4 read count", rd_n - b_rd, n);
    chk("R4 write count", wr_n - b_wr, n);
    chk("R8 bus released", 32'(bus_req), 0);
    chk("R12 irq follows done and enable", 32'(irq), 32'(ie));
    wr(A_STAT, 16'd1);
    rd(A_STAT, v);
    chk("R12 done cleared", v[0], 0);
    chk("R12 irq cleared", 32'(irq), 0);
  endtask

  initial begin
    logic [RW-1:0] v;
    int b_rq;
    bit wd;
    wd = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 mem_rd", 32'(mem_rd), 0);
        chk("R1 mem_wr", 32'(mem_wr), 0);
        chk("R1 irq", 32'(irq), 0);
        for (int a = 0; a < 5; a++) begin
          rd(3'(a), v);
          chk("R1 register zero", v, 0);
        end

        // full-width count
        wr(A_CNT, 16'hFFFF);
        rd(A_CNT, v);
        chk("R14 count holds 65535", v, 16'hFFFF);

        // write protect and level trigger held low
        refill();
        wr(A_SRC, 16'd8); wr(A_DST, 16'd40); wr(A_CNT, 16'd3);
        b_rq = rises;
        wr(A_CTRL, 16'h0021);
        repeat (20) @(negedge clk);
        wr(A_SRC, 16'd5);
        rd(A_SRC, v); chk("R2 source write ignored while enabled", v, 8);
        wr(A_CNT, 16'd7);
        rd(A_CNT, v); chk("R10 count untouched with trigger low", v, 3);
        chk("R10 no request with trigger low", rises - b_rq, 0);
        wr(A_CTRL, 16'h0000);
        wr(A_SRC, 16'd5);
        rd(A_SRC, v); chk("R2 source write accepted when disabled", v, 5);

        // zero count
        wr(A_CNT, 16'd0);
        b_rq = rises;
        wr(A_CTRL, 16'h0021);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk("R9 done with zero count", v[0], 1);
        rd(A_CTRL, v); chk("R9 enable cleared", v[0], 0);
        chk("R9 no bus request", rises - b_rq, 0);
        chk("R12 irq on zero-count completion", 32'(irq), 1);
        wr(A_STAT, 16'd1);

        // edge held while busy serves the next word
        gdly = 2;
        refill();
        expm[40] = expm[8]; expm[41] = expm[9];
        wr(A_SRC, 16'd8); wr(A_DST, 16'd40); wr(A_CNT, 16'd2);
        b_rq = rises;
        wr(A_CTRL, 16'h001D);
        pulse();
        pulse();
        repeat (30) @(negedge clk);
        rd(A_STAT, v); chk("R11 two edges finish two words", v[0], 1);
        rd(A_CNT, v); chk("R11 count after pending edge", v, 0);
        chk("R11 one request per edge", rises - b_rq, 2);
        chk("R11 memory image", mem_diff(), 0);
        wr(A_STAT, 16'd1);

        // disable between words
        refill();
        wr(A_SRC, 16'd8); wr(A_DST, 16'd40); wr(A_CNT, 16'd4);
        b_rq = rises;
        wr(A_CTRL, 16'h001D);
        pulse();
        repeat (12) @(negedge clk);
        wr(A_CTRL, 16'h001C);
        pulse();
        repeat (12) @(negedge clk);
        rd(A_CNT, v); chk("R13 count stops after disable", v, 3);
        chk("R13 no request after disable", rises - b_rq, 1);
        rd(A_STAT, v); chk("R13 done stays clear", v[0], 0);

        // sweep over trigger, arbitration and addressing modes
        for (int c = 0; c < 16; c++)
          run_case(c[0], c[1], c[2], c[3], (c % 3) != 0, 1 + (c * 5) % 8, c % 4);
        run_case(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8, 3);
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8, 0);

        chk("R3 strobes only under grant", nogrant, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      ncmp++;
      nbad++;
      $display("FAIL watchdog: actual expired expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

endmodule